// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a small byte-addressed nonvolatile memory on a two-wire serial bus. It samples the clock line and the data line on the system clock and drives the data line only through an open-drain enable, so a high output means "pull the line low". It recognises bus start and stop conditions and accepts a header byte. When the header is addressed to it, the block takes a word address and write data, or streams read data back to the master. It acknowledges every byte it receives.

A single internal address counter serves both directions. Writes are collected into a page-sized staging buffer and reach the storage array only when the master ends the transfer with a stop. A self-timed write interval then follows. During that interval the block refuses every header, and a master tests for completion by sending a header and watching for the acknowledge. The storage is a plain behavioural register array of 128 or 256 bytes, selected by a parameter.

Top module: `sbee_slave`

## Requirements
- R1: After reset, `sda_oe` is low and the address counter is 0, so a current-address read of two bytes returns the bytes stored at addresses 0 and 1.
- R2: A falling data line while the clock is high is a start, and a start in any state, including in the middle of a transfer, restarts header reception. A rising data line while the clock is high is a stop and returns the block to idle.
- R3: The header byte is sent MSB first. It acknowledges only when its upper four bits are 1010. Bits 3..1 are ignored, and bit 0 selects read (1) or write (0). On any other code the block gives no acknowledge, and the word address and data bytes that follow do not change the counter or the array.
- R4: The block acknowledges an accepted header, a word address and each write data byte by holding the data line low through the 9th clock. It changes its drive only while the clock is low.
- R5: Read data goes out MSB first. A low acknowledge from the master makes the block send the byte at the next address. Sequential reading wraps from the top address to 0.
- R6: A missing master acknowledge ends the read. The data line then stays released through any further clocks until the next start or stop, and the counter points one past the last byte sent.
- R7: Write data is staged and stored only at a stop. The word address increments only within its 8-byte page, wrapping from the page's last byte to its first, and a later byte replaces an earlier byte that landed on the same address.
- R8: For WR_CYCLES system clocks after a stop that stores data, no header, read or write, is acknowledged. After that interval headers are acknowledged again.
- R9: A write header plus a word address with no data, followed by a repeated start and a read header, reads from that word address and stores nothing.
- R10: A current-address read starts at the counter. After a write the counter holds the page-wrapped address that follows the last byte written.
- R11: With the 128-byte option, bit 7 of the word address is ignored, and sequential reading wraps from address 0x7F to 0x00.
- R12: A repeated start after write data bytes discards those bytes. Nothing is stored and no write interval starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The hardest situations to reach are the ones where the master abandons a transfer part way through. One is a repeated start that follows staged write data. Another is a read the master refuses to acknowledge and then keeps clocking. A third is a header that lands inside the self-timed write window. The bench's bit-level master tasks are built so that a caller can stop at any byte boundary. Directed sequences use them to send a repeated start straight after a data byte, to clock nine extra bits after a refused read, and to poll right after a stop. The constrained-random phase then mixes page writes of up to eleven bytes, random reads and current-address reads against a byte-accurate model of the array and counter.

// File: rtl/sbee_pkg.sv
package sbee_pkg;
    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for a start
        ST_DEV,   // receiving the header byte
        ST_ADDR,  // receiving the word address
        ST_WDAT,  // receiving write data
        ST_ACK,   // block drives (or withholds) acknowledge on the 9th clock
        ST_RD,    // shifting out read data
        ST_MACK   // sampling the master's acknowledge
    } sbee_state_e;

    localparam logic [3:0] SBEE_DEV_CODE = 4'b1010;
endpackage

// File: rtl/sbee_line_sync.sv
// Brings the two bus lines into the system clock domain and flags bus events.
// Assumes: the system clock is at least 8x the bus clock, so every bus level
// lasts several system cycles. Idle bus level is high for both lines.
module sbee_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LINES = 2;

    logic [LINES-1:0] meta_q, sync_q, prev_q;

    // Two-flop synchronizer plus one history stage for both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= {sda_i, scl_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge and condition decode on the synchronized copies
    always_comb begin
        scl_s     = sync_q[0];
        sda_s     = sync_q[1];
        scl_rise  = sync_q[0] && !prev_q[0];
        scl_fall  = !sync_q[0] && prev_q[0];
        bus_start = sync_q[0] && prev_q[0] && prev_q[1] && !sync_q[1];
        bus_stop  = sync_q[0] && prev_q[0] && !prev_q[1] && sync_q[1];
    end
endmodule

// File: rtl/sbee_store.sv
// Behavioural byte array with a one-page staging buffer and a write timer.
// Staged bytes are stored at flush (bus stop) and dropped at drop (bus start).
// Assumes: all staged bytes of one transfer share a page; PAGE_BYTES is a power of 2.
module sbee_store #(
    parameter int AW         = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_we,
    input  logic [AW-1:0] stage_addr,
    input  logic [7:0]    stage_data,
    input  logic          flush,
    input  logic          drop,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);
    localparam int DEPTH = 1 << AW;
    localparam int PGW   = $clog2(PAGE_BYTES);
    localparam int HW    = AW - PGW;
    localparam int TW    = $clog2(WR_CYCLES + 1);

    logic [7:0]            cells [DEPTH];
    logic [7:0]            slot_d [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_v;
    logic [HW-1:0]         page_q;
    logic [TW-1:0]         timer_q;
    logic                  commit_go;

    assign commit_go = flush && (slot_v != '0);
    assign busy      = (timer_q != '0);
    assign rd_data   = cells[rd_addr];

    // Staging bookkeeping and self-timed write interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v  <= '0;
            page_q  <= '0;
            timer_q <= '0;
        end else begin
            if (commit_go)
                timer_q <= TW'(WR_CYCLES);
            else if (busy)
                timer_q <= timer_q - 1'b1;
            if (drop || flush)
                slot_v <= '0;
            else if (stage_we) begin
                slot_v[stage_addr[PGW-1:0]] <= 1'b1;
                page_q <= stage_addr[AW-1:PGW];
            end
        end
    end

    // Staging data slots (no reset needed, qualified by slot_v)
    always_ff @(posedge clk) begin
        if (stage_we)
            slot_d[stage_addr[PGW-1:0]] <= stage_data;
    end

    // Array update at commit, one page at a time
    always_ff @(posedge clk) begin
        if (commit_go)
            for (int i = 0; i < PAGE_BYTES; i++)
                if (slot_v[i])
                    cells[{page_q, PGW'(i)}] <= slot_d[i];
    end

    // R8: a new commit never starts inside a running write interval
    assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |-> !busy);
endmodule

// File: rtl/sbee_slave.sv
// Two-wire bus slave protocol engine for a 128/256-byte memory.
// Receives header, word address and data MSB first, drives acknowledges, streams
// read data, and refuses headers while a self-timed write runs.
// Assumes: clk >= 8x the bus clock; sda_i is the wired-AND bus level.
module sbee_slave #(
    parameter bit BIG_ARRAY  = 1'b1,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import sbee_pkg::*;

    localparam int AW  = BIG_ARRAY ? 8 : 7;
    localparam int PGW = $clog2(PAGE_BYTES);

    logic          scl_s, sda_s, rise_ev, fall_ev, start_ev, stop_ev;
    sbee_state_e   state_q, after_q;
    logic [3:0]    bitn_q;
    logic [7:0]    rx_q, tx_q, rd_data;
    logic [AW-1:0] addr_q;
    logic          mack_q, oe_q, busy, stage_we, byte_done;

    sbee_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(rise_ev), .scl_fall(fall_ev),
        .bus_start(start_ev), .bus_stop(stop_ev)
    );

    sbee_store #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_addr(addr_q),
        .stage_data(rx_q), .flush(stop_ev), .drop(start_ev),
        .rd_addr(addr_q), .rd_data(rd_data), .busy(busy)
    );

    // A received byte is complete on the falling clock after its 8th bit
    assign byte_done = fall_ev && (bitn_q == 4'd8);
    assign stage_we  = (state_q == ST_WDAT) && byte_done && !start_ev && !stop_ev;
    assign sda_oe    = oe_q;

    // Protocol sequencing, shifting, acknowledge and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
            bitn_q  <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            addr_q  <= '0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (start_ev) begin
            state_q <= ST_DEV;
            bitn_q  <= '0;
            oe_q    <= 1'b0;
        end else if (stop_ev) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_DEV, ST_ADDR, ST_WDAT: begin
                    if (rise_ev && bitn_q < 4'd8) begin
                        rx_q   <= {rx_q[6:0], sda_s};
                        bitn_q <= bitn_q + 4'd1;
                    end else if (byte_done) begin
                        bitn_q <= '0;
                        if (state_q == ST_DEV) begin
                            if (rx_q[7:4] == SBEE_DEV_CODE && !busy) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_ACK;
                                after_q <= rx_q[0] ? ST_RD : ST_ADDR;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            if (state_q == ST_ADDR)
                                addr_q <= rx_q[AW-1:0];
                            else
                                addr_q <= {addr_q[AW-1:PGW], addr_q[PGW-1:0] + PGW'(1)};
                            oe_q    <= 1'b1;
                            state_q <= ST_ACK;
                            after_q <= ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_ev) begin
                        bitn_q  <= '0;
                        state_q <= after_q;
                        if (after_q == ST_RD) begin
                            tx_q <= rd_data;
                            oe_q <= ~rd_data[7];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (fall_ev) begin
                        if (bitn_q == 4'd7) begin
                            oe_q    <= 1'b0;
                            addr_q  <= addr_q + 1'b1;
                            state_q <= ST_MACK;
                        end else begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            oe_q   <= ~tx_q[6];
                            bitn_q <= bitn_q + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_ev)
                        mack_q <= ~sda_s;
                    else if (fall_ev) begin
                        if (mack_q) begin
                            tx_q    <= rd_data;
                            oe_q    <= ~rd_data[7];
                            bitn_q  <= '0;
                            state_q <= ST_RD;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: while the write interval runs, only idle or header reception is possible
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q == ST_IDLE || state_q == ST_DEV));

    // R2: a start always leads into header reception
    assert_start_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> state_q == ST_DEV);

    // R4: drive changes only while the clock is low, or when a start/stop releases
    assert_drive_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(oe_q) |-> (!scl_s || $past(start_ev || stop_ev)));

    // R4: bit counter never passes one full byte
    assert_bitcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bitn_q <= 4'd8);
endmodule

// File: tb/sbee_slave_tb_top.sv
module sbee_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;      // quarter bus-clock period in system clocks
    localparam int WR_CYC     = 300;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
    logic oe0, oe1, line0, line1, line;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    byte unsigned model [256];
    int           mc = 0;
    byte unsigned rdq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line0 = ~oe0 & (sel ? 1'b1 : sda_m);
    assign line1 = ~oe1 & (sel ? sda_m : 1'b1);
    assign line  = sel ? line1 : line0;

    sbee_slave #(.BIG_ARRAY(1'b1), .PAGE_BYTES(8), .WR_CYCLES(WR_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line0), .sda_oe(oe0));
    sbee_slave #(.BIG_ARRAY(1'b0), .PAGE_BYTES(8), .WR_CYCLES(WR_CYC)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line1), .sda_oe(oe1));

    function automatic int pg_next(int a);
        return (a & ~7) | ((a + 1) & 7);
    endfunction
    function automatic int seq_next(int a, int aw);
        return (a + 1) % (1 << aw);
    endfunction
    function automatic byte unsigned hdr_byte(bit rd, bit good);
        return {good ? 4'b1010 : 4'b1011, 3'($urandom % 8), rd};  // R3: select bits random
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clock_bit(bit v, output bit r);
        sda_m = v; tick(Q);
        scl_m = 1'b1; tick(Q);
        r = line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(byte unsigned b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(bit mack, output byte unsigned d);
        bit r;
        d = 0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            d = {d[6:0], r};
        end
        clock_bit(!mack, r);
    endtask

    // Write transfer; updates the model when the large device is selected
    task automatic wr_run(int a, byte unsigned dq[$], bit poll);
        bit ack;
        int p = a;
        byte unsigned tmp [256];
        bit vld [256];
        for (int k = 0; k < 256; k++) vld[k] = 1'b0;
        bus_start;
        send_byte(hdr_byte(1'b0, 1'b1), ack); chk(ack, "R4 write header ack", ack, 1);
        send_byte(8'(a), ack);                chk(ack, "R4 word address ack", ack, 1);
        foreach (dq[i]) begin
            send_byte(dq[i], ack);            chk(ack, "R4 data byte ack", ack, 1);
            tmp[p & 255] = dq[i]; vld[p & 255] = 1'b1;
            p = pg_next(p);
        end
        bus_stop;
        if (!sel) begin
            for (int k = 0; k < 256; k++) if (vld[k]) model[k] = tmp[k];
            mc = p & 255;
        end
        if (poll) begin
            bus_start;
            send_byte(hdr_byte(1'($urandom % 2), 1'b1), ack);
            chk(!ack, "R8 header refused while busy", ack, 0);
            bus_stop;
        end
        tick(WR_CYC + 60);
        if (poll) begin
            bus_start;
            send_byte(hdr_byte(1'b0, 1'b1), ack);
            chk(ack, "R8 header acknowledged after write", ack, 1);
            bus_stop;
        end
    endtask

    // Read transfer without stop; data pushed into rdq
    task automatic rd_run(bit rnd, int a, int n, output bit ack);
        bit k;
        byte unsigned d;
        rdq.delete();
        bus_start;
        if (rnd) begin
            send_byte(hdr_byte(1'b0, 1'b1), k);
            send_byte(8'(a), k);
            bus_start;
        end
        send_byte(hdr_byte(1'b1, 1'b1), ack);
        if (ack)
            for (int i = 0; i < n; i++) begin
                recv_byte(i < n - 1, d);
                rdq.push_back(d);
            end
    endtask

    task automatic big_read(bit rnd, int a, int n, string tag);
        bit ack;
        rd_run(rnd, a, n, ack);
        bus_stop;
        chk(ack, {tag, " read header ack"}, ack, 1);
        if (rnd) mc = a & 255;
        for (int i = 0; i < n; i++) begin
            chk(rdq.size() > i && rdq[i] == model[mc], tag,
                rdq.size() > i ? int'(rdq[i]) : -1, model[mc]);
            mc = seq_next(mc, 8);
        end
    endtask

    initial begin
        bit ack, r;
        byte unsigned dq [$];
        byte unsigned d;
        void'($urandom(32'd2024));
        tick(6);
        rst_n = 1'b1;
        tick(4);
        // R1: outputs released after reset
        chk(oe0 == 1'b0, "R1 large sda_oe after reset", oe0, 0);
        chk(oe1 == 1'b0, "R1 small sda_oe after reset", oe1, 0);

        // Fill the whole large array
        for (int pg = 0; pg < 32; pg++) begin
            dq.delete();
            for (int i = 0; i < 8; i++) dq.push_back(8'($urandom));
            wr_run(pg * 8, dq, 1'b0);
        end

        // R1: counter returns to 0 at reset, array keeps its content
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        mc = 0;
        big_read(1'b0, 0, 2, "R1 counter zero after reset");

        // R3: wrong device code refused and ignored
        bus_start;
        send_byte(hdr_byte(1'b0, 1'b0), ack);
        chk(!ack, "R3 wrong code not acknowledged", ack, 0);
        send_byte(8'h10, ack);
        send_byte(8'h55, ack);
        chk(!ack, "R3 ignored data not acknowledged", ack, 0);
        bus_stop;
        big_read(1'b0, 0, 1, "R3 counter untouched by ignored transfer");
        big_read(1'b1, 8'h10, 1, "R3 array untouched by ignored transfer");

        // R8: acknowledge polling
        dq = '{8'h5A};
        wr_run(8'h23, dq, 1'b1);
        big_read(1'b1, 8'h23, 1, "R9 random read after byte write");

        // R7: page write of 10 bytes wrapping inside its page
        dq.delete();
        for (int i = 0; i < 10; i++) dq.push_back(8'($urandom));
        wr_run(8'h45, dq, 1'b0);
        big_read(1'b0, 0, 1, "R10 current read after page write");
        big_read(1'b1, 8'h40, 8, "R7 page contents after wrap");

        // R5: sequential read across the top address
        big_read(1'b1, 8'hFD, 5, "R5 sequential wrap to zero");

        // R6: master refuses acknowledge, bus stays released
        rd_run(1'b1, 8'h30, 1, ack);
        chk(rdq.size() == 1 && rdq[0] == model[8'h30], "R6 byte before refusal",
            rdq.size() == 1 ? int'(rdq[0]) : -1, model[8'h30]);
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, r);
            chk(r == 1'b1, "R6 line released after refusal", r, 1);
        end
        bus_stop;
        mc = 8'h31;
        big_read(1'b0, 0, 1, "R6 counter past last byte");

        // R12: repeated start after a data byte discards it
        bus_start;
        send_byte(hdr_byte(1'b0, 1'b1), ack);
        send_byte(8'h50, ack);
        send_byte(8'(~model[8'h50]), ack);
        bus_start;
        send_byte(hdr_byte(1'b1, 1'b1), ack);
        chk(ack, "R2 read header after repeated start", ack, 1);
        recv_byte(1'b0, d);
        chk(d == model[8'h51], "R12 read continues at page-next address", d, model[8'h51]);
        bus_stop;
        bus_start;
        send_byte(hdr_byte(1'b0, 1'b1), ack);
        chk(ack, "R12 no write interval started", ack, 1);
        bus_stop;
        big_read(1'b1, 8'h50, 1, "R12 discarded byte not stored");

        // Constrained random mix
        for (int op = 0; op < 30; op++) begin
            case ($urandom % 3)
                0: begin
                    dq.delete();
                    for (int i = 0; i < 1 + int'($urandom % 11); i++) dq.push_back(8'($urandom));
                    wr_run(int'($urandom % 256), dq, 1'($urandom % 2));
                end
                1: big_read(1'b1, int'($urandom % 256), 1 + int'($urandom % 6), "R9 random read");
                default: big_read(1'b0, 0, 1 + int'($urandom % 4), "R10 current address read");
            endcase
        end

        // R11: small array option
        sel = 1'b1; tick(8);
        dq = '{8'h3C};
        wr_run(8'h85, dq, 1'b0);
        rd_run(1'b1, 8'h05, 1, ack); bus_stop;
        chk(ack, "R11 small header ack", ack, 1);
        chk(rdq.size() == 1 && rdq[0] == 8'h3C, "R11 address MSB ignored",
            rdq.size() == 1 ? int'(rdq[0]) : -1, 8'h3C);
        dq = '{8'h11, 8'h22};
        wr_run(8'h7E, dq, 1'b0);
        dq = '{8'h33};
        wr_run(8'h00, dq, 1'b0);
        rd_run(1'b1, 8'h7E, 3, ack); bus_stop;
        chk(rdq.size() == 3 && rdq[0] == 8'h11 && rdq[1] == 8'h22 && rdq[2] == 8'h33,
            "R11 sequential wrap 7F to 00", rdq.size() == 3 ? int'(rdq[2]) : -1, 8'h33);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule